// File: doc/BRIEF.md
# Ethernet DMA Receive Status Controller

This block follows the receive side of a descriptor-driven Ethernet DMA engine. It holds the receive process in one of three states: stopped, running or suspended. It also keeps a set of sticky status flags that report what the process has met: descriptors the host still owns, completed frames, frames that are too long, stop events and transmit underflows. Software reads the flags as one status word and clears each flag by writing a 1 to its bit.

The states are `RX_STOPPED`, `RX_RUNNING` and `RX_SUSPENDED`, and these transitions connect them:

- **start** moves `RX_STOPPED` to `RX_RUNNING`.
- **halt** moves `RX_RUNNING` or `RX_SUSPENDED` to `RX_STOPPED`.
- **starve** moves `RX_RUNNING` to `RX_SUSPENDED` when a descriptor fetch finds a descriptor owned by the host.
- **poll resume** moves `RX_SUSPENDED` to `RX_RUNNING` on a host poll demand.
- **frame resume** moves `RX_SUSPENDED` to `RX_RUNNING` when a recognized frame arrives.

A halt takes priority over every other transition in the same cycle. Every event is registered, so an input applied in one cycle appears on the outputs after the next rising clock edge.

Top module: `eth_rx_status_ctrl`

## Requirements
- R1: After reset, `status_o` is zero. Only bits 9 (oversize frame), 8 (process stopped), 7 (buffer unavailable), 6 (receive complete) and 5 (transmit underflow) can ever read as 1; every other bit always reads 0.
- R2: A set status bit stays set until a cycle with `wr_en_i`=1 and a 1 at that bit position in `wr_data_i` clears it. Writing 0 to a bit leaves it unchanged.
- R3: When a hardware set event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: `rx_state_o` encodes stopped as 0, running as 1 and suspended as 2. It is 0 after reset. `start_i` in the stopped state moves it to running.
- R5: `stop_i` moves running or suspended to stopped and sets bit 8. `stop_i` while already stopped does not set bit 8. `stop_i` takes priority over every other transition in the same cycle.
- R6: In running, a cycle with `desc_valid_i`=1 and `desc_host_own_i`=1 moves the state to suspended. `rx_susp_o` is 1 exactly while the state is suspended.
- R7: The suspension in R6 sets bit 7 only if the previous descriptor fetch in running found a DMA-owned descriptor (`desc_host_own_i`=0), or if there has been no fetch since the last start or reset.
- R8: In suspended, either `poll_i` or `frame_arrive_i` moves the state back to running.
- R9: In running, `frame_done_i` with `frame_irq_dis_i`=0 sets bit 6 and the state stays running. With `frame_irq_dis_i`=1, bit 6 is not set.
- R10: While a frame is open, bit 9 sets when `rx_bytes_i` exceeds `STD_LIMIT`, or `JUMBO_LIMIT` when `jumbo_en_i`=1. A frame opens on the cycle after `frame_arrive_i` and closes on `frame_done_i`. A count equal to the limit does not set the bit.
- R11: Bit 9 sets at most once per frame. If software clears it during the same frame, it stays clear until a new `frame_arrive_i`.
- R12: `tx_unf_i` sets bit 5. `tx_susp_o` is 1 whenever bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start receive process |
| stop_i | input | 1 | Stop receive process |
| desc_valid_i | input | 1 | Descriptor fetch result valid |
| desc_host_own_i | input | 1 | Fetched descriptor is owned by the host |
| poll_i | input | 1 | Host poll demand strobe |
| frame_arrive_i | input | 1 | Recognized frame arrival (frame start) |
| frame_done_i | input | 1 | Frame completion strobe |
| frame_irq_dis_i | input | 1 | Last descriptor disables the completion interrupt |
| rx_bytes_i | input | CNT_W | Bytes received so far in the current frame |
| jumbo_en_i | input | 1 | Selects the jumbo length limit |
| tx_unf_i | input | 1 | Transmit underflow event |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 32 | Status write data (write 1 to clear) |
| rx_state_o | output | 2 | Receive process state |
| rx_susp_o | output | 1 | Receive process suspended |
| tx_susp_o | output | 1 | Transmit suspended by underflow |
| status_o | output | 32 | Sticky status word |

## Verification
The bench builds the block with `STD_LIMIT`=40, `JUMBO_LIMIT`=120 and `CNT_W`=8. With these values, byte counts drawn at random land on both sides of both length limits, so the oversize-frame flag and its once-per-frame rule come up often in random traffic. The directed cases drive counts exactly at each limit and one byte above it. They also cover the buffer-unavailable flag after a fetch that found a host-owned descriptor and after one that found a DMA-owned descriptor.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef enum logic [1:0] {
        RX_STOPPED   = 2'd0,
        RX_RUNNING   = 2'd1,
        RX_SUSPENDED = 2'd2
    } rx_state_e;

    // Position in the status word of the lowest sticky flag.
    localparam int STS_LSB = 5;
    // Number of sticky flags.
    localparam int STS_N   = 5;

    // Index of each flag inside the sticky vector.
    localparam int IX_UNF = 0;
    localparam int IX_RI  = 1;
    localparam int IX_RU  = 2;
    localparam int IX_RPS = 3;
    localparam int IX_RWT = 4;
endpackage

// File: rtl/rxs_fsm.sv
module rxs_fsm
    import rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      desc_valid_i,
    input  logic      desc_host_own_i,
    input  logic      poll_i,
    input  logic      frame_arrive_i,
    input  logic      frame_done_i,
    input  logic      frame_irq_dis_i,
    output rx_state_e state_o,
    output logic      ev_stop_o,
    output logic      ev_unavail_o,
    output logic      ev_done_o
);
    rx_state_e state_q, state_d;
    logic      prev_dma_q, prev_dma_d;

    // State register and ownership memory of the previous fetch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RX_STOPPED;
            prev_dma_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            prev_dma_q <= prev_dma_d;
        end
    end

    // Next-state logic and event outputs.
    always_comb begin
        state_d      = state_q;
        prev_dma_d   = prev_dma_q;
        ev_stop_o    = 1'b0;
        ev_unavail_o = 1'b0;
        ev_done_o    = (state_q == RX_RUNNING) && frame_done_i && !frame_irq_dis_i;
        unique case (state_q)
            RX_STOPPED: begin
                if (!stop_i && start_i) begin
                    state_d    = RX_RUNNING;
                    prev_dma_d = 1'b1;
                end
            end
            RX_RUNNING: begin
                if (stop_i) begin
                    state_d   = RX_STOPPED;
                    ev_stop_o = 1'b1;
                end else if (desc_valid_i) begin
                    prev_dma_d = !desc_host_own_i;
                    if (desc_host_own_i) begin
                        state_d      = RX_SUSPENDED;
                        ev_unavail_o = prev_dma_q;
                    end
                end
            end
            RX_SUSPENDED: begin
                if (stop_i) begin
                    state_d   = RX_STOPPED;
                    ev_stop_o = 1'b1;
                end else if (poll_i || frame_arrive_i) begin
                    state_d = RX_RUNNING;
                end
            end
            default: state_d = RX_STOPPED;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/rxs_wdt.sv
module rxs_wdt #(
    parameter int STD_LIMIT   = 2048,
    parameter int JUMBO_LIMIT = 10240,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_arrive_i,
    input  logic             frame_done_i,
    input  logic [CNT_W-1:0] rx_bytes_i,
    input  logic             jumbo_en_i,
    output logic             ev_long_o
);
    localparam logic [CNT_W-1:0] LIM_STD = CNT_W'(STD_LIMIT);
    localparam logic [CNT_W-1:0] LIM_JMB = CNT_W'(JUMBO_LIMIT);

    logic in_frame_q;
    logic fired_q;
    logic [CNT_W-1:0] limit;

    assign limit     = jumbo_en_i ? LIM_JMB : LIM_STD;
    assign ev_long_o = in_frame_q && !fired_q && (rx_bytes_i > limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            fired_q    <= 1'b0;
        end else if (frame_arrive_i) begin
            in_frame_q <= 1'b1;
            fired_q    <= 1'b0;
        end else begin
            if (frame_done_i) in_frame_q <= 1'b0;
            if (ev_long_o)    fired_q    <= 1'b1;
        end
    end
endmodule

// File: rtl/rxs_sticky.sv
module rxs_sticky #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end
        assign q_o[i] = q;
    end
endmodule

// File: rtl/eth_rx_status_ctrl.sv
module eth_rx_status_ctrl
    import rxs_pkg::*;
#(
    parameter int STD_LIMIT   = 2048,
    parameter int JUMBO_LIMIT = 10240,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             desc_valid_i,
    input  logic             desc_host_own_i,
    input  logic             poll_i,
    input  logic             frame_arrive_i,
    input  logic             frame_done_i,
    input  logic             frame_irq_dis_i,
    input  logic [CNT_W-1:0] rx_bytes_i,
    input  logic             jumbo_en_i,
    input  logic             tx_unf_i,
    input  logic             wr_en_i,
    input  logic [31:0]      wr_data_i,
    output logic [1:0]       rx_state_o,
    output logic             rx_susp_o,
    output logic             tx_susp_o,
    output logic [31:0]      status_o
);
    localparam int STS_MSB = STS_LSB + STS_N - 1;

    rx_state_e        state;
    logic             ev_stop, ev_unavail, ev_done, ev_long;
    logic [STS_N-1:0] set_vec, clr_vec, sts;
    logic             unused_wr;

    rxs_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .stop_i          (stop_i),
        .desc_valid_i    (desc_valid_i),
        .desc_host_own_i (desc_host_own_i),
        .poll_i          (poll_i),
        .frame_arrive_i  (frame_arrive_i),
        .frame_done_i    (frame_done_i),
        .frame_irq_dis_i (frame_irq_dis_i),
        .state_o         (state),
        .ev_stop_o       (ev_stop),
        .ev_unavail_o    (ev_unavail),
        .ev_done_o       (ev_done)
    );

    rxs_wdt #(
        .STD_LIMIT   (STD_LIMIT),
        .JUMBO_LIMIT (JUMBO_LIMIT),
        .CNT_W       (CNT_W)
    ) u_wdt (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_arrive_i (frame_arrive_i),
        .frame_done_i   (frame_done_i),
        .rx_bytes_i     (rx_bytes_i),
        .jumbo_en_i     (jumbo_en_i),
        .ev_long_o      (ev_long)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[IX_UNF] = tx_unf_i;
        set_vec[IX_RI]  = ev_done;
        set_vec[IX_RU]  = ev_unavail;
        set_vec[IX_RPS] = ev_stop;
        set_vec[IX_RWT] = ev_long;
        clr_vec         = wr_en_i ? wr_data_i[STS_MSB:STS_LSB] : '0;
    end

    rxs_sticky #(.W(STS_N)) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (sts)
    );

    always_comb begin
        status_o                  = '0;
        status_o[STS_MSB:STS_LSB] = sts;
    end

    assign rx_state_o = state;
    assign rx_susp_o  = (state == RX_SUSPENDED);
    assign tx_susp_o  = sts[IX_UNF];
    assign unused_wr  = ^{wr_data_i[31:STS_MSB+1], wr_data_i[STS_LSB-1:0]};
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic             desc_valid_i,
    input logic             desc_host_own_i,
    input logic             poll_i,
    input logic             frame_arrive_i,
    input logic             frame_done_i,
    input logic             frame_irq_dis_i,
    input logic             tx_unf_i,
    input logic             wr_en_i,
    input logic [31:0]      wr_data_i,
    input logic [1:0]       rx_state_o,
    input logic             rx_susp_o,
    input logic [31:0]      status_o
);
    p_only_known_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~32'h0000_03E0) == 32'h0)
        else $error("p_only_known_bits_r1");

    p_sticky_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((status_o & $past(status_o)) == $past(status_o)))
        else $error("p_sticky_no_write_r2");

    p_write_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i == 32'h0) |=> ((status_o & $past(status_o)) == $past(status_o)))
        else $error("p_write_zero_r2");

    p_unf_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_unf_i |=> status_o[5])
        else $error("p_unf_set_wins_r3");

    p_legal_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_state_o != 2'd3)
        else $error("p_legal_state_r4");

    p_start_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state_o == 2'd0 && start_i && !stop_i) |=> rx_state_o == 2'd1)
        else $error("p_start_run_r4");

    p_stop_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state_o != 2'd0 && stop_i) |=> (rx_state_o == 2'd0 && status_o[8]))
        else $error("p_stop_sets_r5");

    p_starve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state_o == 2'd1 && !stop_i && desc_valid_i && desc_host_own_i) |=> rx_susp_o)
        else $error("p_starve_r6");

    p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state_o == 2'd2 && !stop_i && (poll_i || frame_arrive_i)) |=> rx_state_o == 2'd1)
        else $error("p_resume_r8");

    p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state_o == 2'd1 && !stop_i && !desc_valid_i && frame_done_i && !frame_irq_dis_i)
        |=> (rx_state_o == 2'd1 && status_o[6]))
        else $error("p_done_irq_r9");
endmodule

bind eth_rx_status_ctrl rxs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .stop_i          (stop_i),
    .desc_valid_i    (desc_valid_i),
    .desc_host_own_i (desc_host_own_i),
    .poll_i          (poll_i),
    .frame_arrive_i  (frame_arrive_i),
    .frame_done_i    (frame_done_i),
    .frame_irq_dis_i (frame_irq_dis_i),
    .tx_unf_i        (tx_unf_i),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .rx_state_o      (rx_state_o),
    .rx_susp_o       (rx_susp_o),
    .status_o        (status_o)
);

// File: tb/sim_eth_rx_status_ctrl.sv
module sim_eth_rx_status_ctrl;
    localparam int STD_L = 40;
    localparam int JMB_L = 120;
    localparam int CW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i, stop_i, desc_valid_i, desc_host_own_i, poll_i;
    logic frame_arrive_i, frame_done_i, frame_irq_dis_i, jumbo_en_i, tx_unf_i, wr_en_i;
    logic [CW-1:0] rx_bytes_i;
    logic [31:0]   wr_data_i;
    logic [1:0]    rx_state_o;
    logic          rx_susp_o, tx_susp_o;
    logic [31:0]   status_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int       m_st;
    logic [31:0] m_sts;
    bit       m_prev, m_inf, m_fired;

    always #4 clk = ~clk;

    eth_rx_status_ctrl #(.STD_LIMIT(STD_L), .JUMBO_LIMIT(JMB_L), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .desc_valid_i(desc_valid_i), .desc_host_own_i(desc_host_own_i), .poll_i(poll_i),
        .frame_arrive_i(frame_arrive_i), .frame_done_i(frame_done_i),
        .frame_irq_dis_i(frame_irq_dis_i), .rx_bytes_i(rx_bytes_i), .jumbo_en_i(jumbo_en_i),
        .tx_unf_i(tx_unf_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rx_state_o(rx_state_o), .rx_susp_o(rx_susp_o), .tx_susp_o(tx_susp_o),
        .status_o(status_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        start_i = 0; stop_i = 0; desc_valid_i = 0; desc_host_own_i = 0; poll_i = 0;
        frame_arrive_i = 0; frame_done_i = 0; frame_irq_dis_i = 0; tx_unf_i = 0;
        wr_en_i = 0; wr_data_i = 0;
    endtask

    function automatic int lim_now();
        return jumbo_en_i ? JMB_L : STD_L;
    endfunction

    // One clock: compute expected next values, clock, compare everything.
    task automatic cyc();
        int  n_st = m_st;
        bit  n_prev = m_prev, n_inf = m_inf, n_fired = m_fired;
        logic [31:0] ev = 0;
        logic [31:0] clr;
        bit  ev_long;
        case (m_st)
            0: if (!stop_i && start_i) begin n_st = 1; n_prev = 1; end
            1: if (stop_i) begin n_st = 0; ev[8] = 1; end
               else if (desc_valid_i) begin
                   n_prev = !desc_host_own_i;
                   if (desc_host_own_i) begin n_st = 2; ev[7] = m_prev; end
               end
            default: if (stop_i) begin n_st = 0; ev[8] = 1; end
                     else if (poll_i || frame_arrive_i) n_st = 1;
        endcase
        if (m_st == 1 && frame_done_i && !frame_irq_dis_i) ev[6] = 1;
        ev_long = m_inf && !m_fired && (int'(rx_bytes_i) > lim_now());
        ev[9] = ev_long;
        ev[5] = tx_unf_i;
        if (frame_arrive_i) begin n_inf = 1; n_fired = 0; end
        else begin
            if (frame_done_i) n_inf = 0;
            if (ev_long) n_fired = 1;
        end
        clr = wr_en_i ? (wr_data_i & 32'h3E0) : 32'h0;
        @(posedge clk);
        #1;
        m_st = n_st; m_prev = n_prev; m_inf = n_inf; m_fired = n_fired;
        m_sts = (m_sts & ~clr) | ev;
        chk("R4 state", {30'b0, rx_state_o}, m_st);
        chk("R6 rx_susp_o", {31'b0, rx_susp_o}, {31'b0, m_st == 2});
        chk("R12 tx_susp_o", {31'b0, tx_susp_o}, {31'b0, m_sts[5]});
        chk("R12 bit5", {31'b0, status_o[5]}, {31'b0, m_sts[5]});
        chk("R9 bit6", {31'b0, status_o[6]}, {31'b0, m_sts[6]});
        chk("R7 bit7", {31'b0, status_o[7]}, {31'b0, m_sts[7]});
        chk("R5 bit8", {31'b0, status_o[8]}, {31'b0, m_sts[8]});
        chk("R10 bit9", {31'b0, status_o[9]}, {31'b0, m_sts[9]});
        chk("R1 other bits", status_o & ~32'h3E0, 32'h0);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        idle();
        rx_bytes_i = 0; jumbo_en_i = 0;
        m_st = 0; m_sts = 0; m_prev = 1; m_inf = 0; m_fired = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset status", status_o, 32'h0);
        chk("R4 reset state", {30'b0, rx_state_o}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R4 start
        start_i = 1; cyc();
        chk("R4 start to running", {30'b0, rx_state_o}, 32'd1);
        // R6/R7 first fetch host-owned
        desc_valid_i = 1; desc_host_own_i = 1; cyc();
        chk("R6 suspended", {30'b0, rx_state_o}, 32'd2);
        chk("R7 first starve sets bit7", {31'b0, status_o[7]}, 32'd1);
        // R2 write zero, then W1C
        wr_en_i = 1; wr_data_i = 32'h0; cyc();
        chk("R2 write zero keeps", {31'b0, status_o[7]}, 32'd1);
        wr_en_i = 1; wr_data_i = 32'h80; cyc();
        chk("R2 w1c clears", {31'b0, status_o[7]}, 32'd0);
        // R8 poll resume; starve again after host-owned prev: no bit7
        poll_i = 1; cyc();
        chk("R8 poll resume", {30'b0, rx_state_o}, 32'd1);
        desc_valid_i = 1; desc_host_own_i = 1; cyc();
        chk("R7 prev host-owned no bit7", {31'b0, status_o[7]}, 32'd0);
        frame_arrive_i = 1; cyc();
        chk("R8 frame resume", {30'b0, rx_state_o}, 32'd1);
        desc_valid_i = 1; desc_host_own_i = 0; cyc();
        desc_valid_i = 1; desc_host_own_i = 1; cyc();
        chk("R7 prev dma-owned sets bit7", {31'b0, status_o[7]}, 32'd1);
        poll_i = 1; cyc();
        // R9
        frame_done_i = 1; frame_irq_dis_i = 1; cyc();
        chk("R9 irq disabled", {31'b0, status_o[6]}, 32'd0);
        frame_done_i = 1; frame_irq_dis_i = 0; cyc();
        chk("R9 irq set", {31'b0, status_o[6]}, 32'd1);
        chk("R9 stays running", {30'b0, rx_state_o}, 32'd1);
        // R3 set wins
        tx_unf_i = 1; wr_en_i = 1; wr_data_i = 32'h20; cyc();
        chk("R3 set beats clear", {31'b0, status_o[5]}, 32'd1);
        // R10/R11 watchdog
        frame_arrive_i = 1; jumbo_en_i = 0; rx_bytes_i = 0; cyc();
        jumbo_en_i = 0; rx_bytes_i = CW'(STD_L); cyc();
        chk("R10 at limit no set", {31'b0, status_o[9]}, 32'd0);
        jumbo_en_i = 0; rx_bytes_i = CW'(STD_L + 1); cyc();
        chk("R10 over limit set", {31'b0, status_o[9]}, 32'd1);
        jumbo_en_i = 0; rx_bytes_i = CW'(STD_L + 2); wr_en_i = 1; wr_data_i = 32'h200; cyc();
        jumbo_en_i = 0; rx_bytes_i = CW'(STD_L + 3); cyc();
        chk("R11 once per frame", {31'b0, status_o[9]}, 32'd0);
        frame_arrive_i = 1; jumbo_en_i = 1; rx_bytes_i = 0; cyc();
        jumbo_en_i = 1; rx_bytes_i = CW'(JMB_L); cyc();
        chk("R10 jumbo at limit", {31'b0, status_o[9]}, 32'd0);
        jumbo_en_i = 1; rx_bytes_i = CW'(JMB_L + 1); cyc();
        chk("R10 jumbo over", {31'b0, status_o[9]}, 32'd1);
        // R5 stop
        stop_i = 1; start_i = 1; cyc();
        chk("R5 stop", {30'b0, rx_state_o}, 32'd0);
        chk("R5 stop bit8", {31'b0, status_o[8]}, 32'd1);
        wr_en_i = 1; wr_data_i = 32'h100; cyc();
        stop_i = 1; cyc();
        chk("R5 stop when stopped", {31'b0, status_o[8]}, 32'd0);

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            start_i         = ($urandom % 16) == 0;
            stop_i          = ($urandom % 40) == 0;
            desc_valid_i    = ($urandom % 3) == 0;
            desc_host_own_i = $urandom % 2;
            poll_i          = ($urandom % 10) == 0;
            frame_arrive_i  = ($urandom % 8) == 0;
            frame_done_i    = ($urandom % 8) == 0;
            frame_irq_dis_i = $urandom % 2;
            tx_unf_i        = ($urandom % 30) == 0;
            wr_en_i         = ($urandom % 6) == 0;
            wr_data_i       = $urandom;
            jumbo_en_i      = $urandom % 2;
            rx_bytes_i      = CW'($urandom % 160);
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule